// File: doc/BRIEF.md
# SDRAM Geometry Probe Engine

This block discovers the geometry of one external SDRAM bank by address aliasing. The bank must already be set up for its widest reach: 11 column bits and 4 internal banks. The block then writes nine self-describing words through a simple request/acknowledge memory master port. Each word goes to an address that only exists if the device has a given number of columns or rows. Every write is read back at once. When all nine have been written, three verdict reads are made. They find out which pattern survived at the widest column address, at the widest row address and at the row-12 address, which also tells the internal bank count.

From those three words the block forms a 4-bit configuration nibble. Bit 3 is the four-bank flag and bits 1:0 hold the column code. It also forms an 8-bit row mask and an 8-bit bank end value. These values are held until the next probe ends. Any inconsistent word stops the probe at once and reports bad memory, with the nibble, the end value and the mask all forced to zero. A one-cycle start pulse launches a probe, and a one-cycle done pulse closes it. The memory port is fully handshaked, so any memory latency is tolerated.

Top module: `sdram_geo_probe`

## Requirements
- R1: A `start` pulse seen while the engine is idle launches a probe, and `start` is ignored while a probe is running. Each probe ends with `done` high for exactly one cycle.
- R2: A probe issues nine writes in this fixed order (address, data): 0x0E001E00/0x0B0B0B0B, 0x0E000E00/0x0A0A0A0A, 0x0E000600/0x09090909, 0x0E000200/0x08080808, 0x0F000000/0x3F3F3F3F, 0x07000000/0x1F1F1F1F, 0x03000000/0x0F0F0F0F, 0x01000000/0x07070707, 0x00000000/0xAAAAAAAA. After the nine writes come three reads, at 0x03000000, then 0x0F000000, then 0x0E001E00.
- R3: Every write is followed directly by a read of the same address. If the word read differs from the word written, the probe fails.
- R4: `mem_req` stays high, with `mem_we`, `mem_addr` and `mem_wdata` unchanged, until the cycle in which `mem_ack` is high. The probe works for any acknowledge latency.
- R5: The read at 0x03000000 sets the bank result. 0xAAAAAAAA means 2 banks (nibble bit 3 = 0). 0x07070707 or 0x0F0F0F0F means 4 banks (nibble bit 3 = 1). Any other value fails the probe.
- R6: The read at 0x0F000000 is the row word. It must lie between 0x07070707 and 0x3F3F3F3F inclusive, and all four of its bytes must be equal. Otherwise the probe fails. On success `row_mask` is the low byte of the row word.
- R7: The read at 0x0E001E00 is the column word. It must lie between 0x08080808 and 0x0B0B0B0B inclusive, with all four bytes equal. Otherwise the probe fails. The column code is the low byte minus 8 (0 to 3).
- R8: On success, `geo_cfg` = {four-bank flag, 0, column code[1:0]}.
- R9: On success, `bank_end` = (row_mask >> (3 − column code)) + 1, taken over 8 bits.
- R10: On failure, `mem_bad` = 1 and `geo_cfg`, `bank_end` and `row_mask` are all 0. On success, `mem_bad` = 0.
- R11: A failure ends the probe at the acknowledge of the failing read. No further memory request is issued.
- R12: The result outputs change only in the `done` cycle and hold between probes. A `start` given in the `done` cycle begins a new probe on the next cycle, while the old results stay visible until the new `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle probe launch |
| done | output | 1 | One-cycle probe completion pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Access byte address |
| mem_wdata | output | 32 | Write word |
| mem_rdata | input | 32 | Read word, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| geo_cfg | output | 4 | {four-bank, 0, column code} |
| bank_end | output | 8 | Bank end value |
| row_mask | output | 8 | Row mask byte |
| mem_bad | output | 1 | Probe found inconsistent memory |

## Verification
The completion pulse of one probe and the launch of the next can fall in the same cycle. The bench provokes this by driving `start` exactly in the cycle where `done` is high, having first switched the aliasing model to a different geometry. It then checks three things: a memory request appears on the very next cycle, the previous nibble is still on the outputs in the middle of the new run, and only the second `done` brings the new geometry. A stray `start` given during that run must not change the access count.

// File: rtl/sdram_geo_probe_pkg.sv
package sdram_geo_probe_pkg;

    localparam int AW        = 32;
    localparam int DW        = 32;
    localparam int N_COL     = 4;
    localparam int N_ROW     = 5;
    localparam int N_STEP    = N_COL + N_ROW;
    localparam int STEP_W    = $clog2(N_STEP);
    localparam int IDX_COLMAX = 0;
    localparam int IDX_ROWMAX = N_COL;
    localparam int IDX_ROW12  = N_COL + 2;
    localparam int IDX_ROW11  = N_COL + 3;
    localparam int IDX_COLMIN = N_COL - 1;
    localparam int IDX_LAST   = N_STEP - 1;

    typedef logic [AW-1:0]     addr_t;
    typedef logic [DW-1:0]     word_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_WR, ST_RB, ST_BANK, ST_ROW, ST_COL
    } probe_st_e;

    typedef enum logic [1:0] {
        PH_RB, PH_BANK, PH_ROW, PH_COL
    } probe_ph_e;

    typedef struct packed {
        logic       pass;
        logic       four;
        logic [7:0] mask;
        logic [1:0] code;
    } verdict_t;

    // Alias address of probe step i: column steps first, then row steps.
    function automatic addr_t step_addr(input step_t i);
        addr_t a;
        if (int'(i) < N_COL)
            a = 32'h0E00_0000 | ((32'h0000_2000 >> i) - 32'h0000_0200);
        else if (int'(i) < IDX_LAST)
            a = (32'h1000_0000 >> (int'(i) - N_COL)) - 32'h0100_0000;
        else
            a = '0;
        return a;
    endfunction

    // Self-describing pattern of probe step i (one byte repeated).
    function automatic word_t step_pat(input step_t i);
        logic [7:0] b;
        if (int'(i) < N_COL)
            b = 8'h0B - 8'(i);
        else if (int'(i) < IDX_LAST)
            b = (8'h40 >> (int'(i) - N_COL)) - 8'h01;
        else
            b = 8'hAA;
        return {4{b}};
    endfunction

    function automatic logic bytes_same(input word_t w);
        return (w[31:24] == w[7:0]) && (w[23:16] == w[7:0]) && (w[15:8] == w[7:0]);
    endfunction

endpackage

// File: rtl/geo_judge.sv
module geo_judge
    import sdram_geo_probe_pkg::*;
(
    input  probe_ph_e phase,
    input  step_t     idx,
    input  word_t     rdata,
    output verdict_t  vd
);
    word_t pat_row11, pat_row12, pat_rowmax, pat_2bank, pat_colmax, pat_colmin;

    always_comb begin
        pat_row11  = step_pat(step_t'(IDX_ROW11));
        pat_row12  = step_pat(step_t'(IDX_ROW12));
        pat_rowmax = step_pat(step_t'(IDX_ROWMAX));
        pat_2bank  = step_pat(step_t'(IDX_LAST));
        pat_colmax = step_pat(step_t'(IDX_COLMAX));
        pat_colmin = step_pat(step_t'(IDX_COLMIN));

        vd      = '0;
        vd.mask = rdata[7:0];
        vd.code = 2'(rdata[7:0] - pat_colmin[7:0]);
        unique case (phase)
            PH_RB:   vd.pass = (rdata == step_pat(idx));
            PH_BANK: begin
                vd.four = (rdata == pat_row11) || (rdata == pat_row12);
                vd.pass = vd.four || (rdata == pat_2bank);
            end
            PH_ROW:  vd.pass = (rdata >= pat_row11) && (rdata <= pat_rowmax) && bytes_same(rdata);
            PH_COL:  vd.pass = (rdata >= pat_colmin) && (rdata <= pat_colmax) && bytes_same(rdata);
            default: vd.pass = 1'b0;
        endcase
    end
endmodule

// File: rtl/geo_seq.sv
module geo_seq
    import sdram_geo_probe_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      mem_ack,
    input  logic      pass,
    output logic      mem_req,
    output logic      mem_we,
    output addr_t     mem_addr,
    output word_t     mem_wdata,
    output logic      evt,
    output probe_ph_e phase,
    output step_t     idx
);
    probe_st_e st;

    always_comb begin
        mem_req   = (st != ST_IDLE);
        mem_we    = (st == ST_WR);
        mem_wdata = (st == ST_WR) ? step_pat(idx) : '0;
        unique case (st)
            ST_BANK: mem_addr = step_addr(step_t'(IDX_ROW12));
            ST_ROW:  mem_addr = step_addr(step_t'(IDX_ROWMAX));
            ST_COL:  mem_addr = step_addr(step_t'(IDX_COLMAX));
            default: mem_addr = step_addr(idx);
        endcase
        unique case (st)
            ST_BANK: phase = PH_BANK;
            ST_ROW:  phase = PH_ROW;
            ST_COL:  phase = PH_COL;
            default: phase = PH_RB;
        endcase
        evt = mem_ack && (st inside {ST_RB, ST_BANK, ST_ROW, ST_COL});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= ST_IDLE;
            idx <= '0;
        end else begin
            unique case (st)
                ST_IDLE: if (start) begin
                    st  <= ST_WR;
                    idx <= '0;
                end
                ST_WR:   if (mem_ack) st <= ST_RB;
                ST_RB:   if (mem_ack) begin
                    if (!pass)                   st <= ST_IDLE;
                    else if (int'(idx) == IDX_LAST) st <= ST_BANK;
                    else begin
                        st  <= ST_WR;
                        idx <= idx + 1'b1;
                    end
                end
                ST_BANK: if (mem_ack) st <= pass ? ST_ROW : ST_IDLE;
                ST_ROW:  if (mem_ack) st <= pass ? ST_COL : ST_IDLE;
                ST_COL:  if (mem_ack) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R4: an unacknowledged request holds its command, address and data
    a_r4_req_hold: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

    // R3: an acknowledged write is followed by a read of the same address
    a_r3_readback: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_ack |=> mem_req && !mem_we && $stable(mem_addr));

    // R11: a failing verdict leaves the port quiet
    a_r11_stop: assert property (@(posedge clk) disable iff (rst)
        evt && !pass |=> !mem_req);
endmodule

// File: rtl/geo_result.sv
module geo_result
    import sdram_geo_probe_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       evt,
    input  probe_ph_e  phase,
    input  verdict_t   vd,
    output logic       done,
    output logic [3:0] geo_cfg,
    output logic [7:0] bank_end,
    output logic [7:0] row_mask,
    output logic       mem_bad
);
    logic       four_t;
    logic [7:0] mask_t;

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            geo_cfg  <= '0;
            bank_end <= '0;
            row_mask <= '0;
            mem_bad  <= 1'b0;
            four_t   <= 1'b0;
            mask_t   <= '0;
        end else begin
            done <= 1'b0;
            if (evt) begin
                if (!vd.pass) begin
                    geo_cfg  <= '0;
                    bank_end <= '0;
                    row_mask <= '0;
                    mem_bad  <= 1'b1;
                    done     <= 1'b1;
                end else begin
                    unique case (phase)
                        PH_BANK: four_t <= vd.four;
                        PH_ROW:  mask_t <= vd.mask;
                        PH_COL: begin
                            geo_cfg  <= {four_t, 1'b0, vd.code};
                            bank_end <= (mask_t >> (2'd3 - vd.code)) + 8'd1;
                            row_mask <= mask_t;
                            mem_bad  <= 1'b0;
                            done     <= 1'b1;
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // R1: completion is a single-cycle pulse
    a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10: a failed probe reports all-zero geometry
    a_r10_bad_zero: assert property (@(posedge clk) disable iff (rst)
        done && mem_bad |-> geo_cfg == 4'd0 && bank_end == 8'd0 && row_mask == 8'd0);

    // R9: a successful probe never reports an empty bank
    a_r9_end_nonzero: assert property (@(posedge clk) disable iff (rst)
        done && !mem_bad |-> bank_end != 8'd0);

    // R12: results move only with the completion pulse
    a_r12_hold: assert property (@(posedge clk) disable iff (rst)
        !$stable(geo_cfg) || !$stable(bank_end) || !$stable(mem_bad) |-> done);
endmodule

// File: rtl/sdram_geo_probe.sv
module sdram_geo_probe
    import sdram_geo_probe_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    output logic          done,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic [3:0]    geo_cfg,
    output logic [7:0]    bank_end,
    output logic [7:0]    row_mask,
    output logic          mem_bad
);
    logic      evt;
    probe_ph_e phase;
    step_t     idx;
    verdict_t  vd;

    geo_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .mem_ack   (mem_ack),
        .pass      (vd.pass),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .evt       (evt),
        .phase     (phase),
        .idx       (idx)
    );

    geo_judge u_judge (
        .phase (phase),
        .idx   (idx),
        .rdata (mem_rdata),
        .vd    (vd)
    );

    geo_result u_result (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .phase    (phase),
        .vd       (vd),
        .done     (done),
        .geo_cfg  (geo_cfg),
        .bank_end (bank_end),
        .row_mask (row_mask),
        .mem_bad  (mem_bad)
    );
endmodule

// File: tb/sdram_geo_probe_tb_top.sv
`timescale 1ns/1ps
module sdram_geo_probe_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        done, mem_req, mem_we, mem_ack, mem_bad;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [3:0]  geo_cfg;
    logic [7:0]  bank_end, row_mask;

    always #5 clk = ~clk;

    sdram_geo_probe dut_i (
        .clk(clk), .rst(rst), .start(start), .done(done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .geo_cfg(geo_cfg), .bank_end(bank_end), .row_mask(row_mask), .mem_bad(mem_bad)
    );

    // ---------------- aliasing memory model ----------------
    logic [31:0] keep_m = 32'hFFFF_FFFF;
    logic        fold_m = 1'b0;
    int          lat_m  = 0;
    int          gn_m   = 0;
    logic [31:0] gx_m   = '0;
    logic        mdl_clr = 1'b0;

    logic [31:0] mem_m [logic [31:0]];
    int          nops, rd_n, cnt, viol;
    logic        log_we   [0:31];
    logic [31:0] log_addr [0:31];
    logic [31:0] log_wd   [0:31];
    logic        prev_pend;
    logic [31:0] prev_addr;

    function automatic logic [31:0] key_of(input logic [31:0] a);
        logic [31:0] k;
        k = a & keep_m;
        if (fold_m && k[27:26] == 2'b00) k[25:24] = 2'b00;
        return k;
    endfunction

    always @(posedge clk) begin
        if (rst || mdl_clr) begin
            mem_ack <= 1'b0;
            mem_rdata <= '0;
            cnt <= 0; nops <= 0; rd_n <= 0;
            mem_m.delete();
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (cnt >= lat_m) begin
                cnt <= 0;
                mem_ack <= 1'b1;
                if (nops < 32) begin
                    log_we[nops]   <= mem_we;
                    log_addr[nops] <= mem_addr;
                    log_wd[nops]   <= mem_wdata;
                end
                nops <= nops + 1;
                if (mem_we) begin
                    mem_m[key_of(mem_addr)] = mem_wdata;
                end else begin
                    logic [31:0] d;
                    d = mem_m.exists(key_of(mem_addr)) ? mem_m[key_of(mem_addr)] : 32'h0;
                    if (rd_n + 1 == gn_m) d = d ^ gx_m;
                    rd_n <= rd_n + 1;
                    mem_rdata <= d;
                end
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    // port-level stability monitor (R4)
    always @(posedge clk) begin
        if (rst) begin
            viol <= 0; prev_pend <= 1'b0; prev_addr <= '0;
        end else begin
            if (prev_pend && (!mem_req || mem_addr != prev_addr)) viol <= viol + 1;
            prev_pend <= mem_req && !mem_ack;
            prev_addr <= mem_addr;
        end
    end

    // ---------------- checking ----------------
    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [31:0] exp_a [9] = '{32'h0E001E00, 32'h0E000E00, 32'h0E000600, 32'h0E000200,
                               32'h0F000000, 32'h07000000, 32'h03000000, 32'h01000000, 32'h00000000};
    logic [31:0] exp_p [9] = '{32'h0B0B0B0B, 32'h0A0A0A0A, 32'h09090909, 32'h08080808,
                               32'h3F3F3F3F, 32'h1F1F1F1F, 32'h0F0F0F0F, 32'h07070707, 32'hAAAAAAAA};

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic set_model(input logic [31:0] keep, input bit fold, input int lat,
                             input int gn, input logic [31:0] gx);
        keep_m = keep; fold_m = fold; lat_m = lat; gn_m = gn; gx_m = gx;
    endtask

    task automatic wait_done(input string req, output bit ok);
        ok = 0;
        for (int c = 0; c < 3000; c++) begin
            if (done) begin ok = 1; break; end
            @(negedge clk);
        end
        chk(req, "done seen", 32'(ok), 32'd1);
    endtask

    task automatic launch();
        @(negedge clk);
        start = 1'b1; mdl_clr = 1'b1;
        @(negedge clk);
        start = 1'b0; mdl_clr = 1'b0;
    endtask

    task automatic expect_good(input string tag, input logic [3:0] cfg, input logic [7:0] endv,
                               input logic [7:0] mask);
        bit ok;
        wait_done(tag, ok);
        chk(tag, "geo_cfg", 32'(geo_cfg), 32'(cfg));
        chk(tag, "bank_end", 32'(bank_end), 32'(endv));
        chk(tag, "row_mask", 32'(row_mask), 32'(mask));
        chk("R10", "mem_bad clear on success", 32'(mem_bad), 32'd0);
        @(negedge clk);
        chk("R1", "done lasts one cycle", 32'(done), 32'd0);
        chk(tag, "access count", 32'(nops), 32'd21);
    endtask

    task automatic expect_bad(input string tag, input int ops);
        bit ok;
        wait_done(tag, ok);
        chk(tag, "mem_bad", 32'(mem_bad), 32'd1);
        chk("R10", "zero outputs on failure", {geo_cfg, bank_end, row_mask}, 32'd0);
        repeat (10) @(negedge clk);
        chk("R11", "no access after failure", 32'(nops), 32'(ops));
        chk("R11", "port idle after failure", 32'(mem_req), 32'd0);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk("R1", "done after reset", 32'(done), 32'd0);
        chk("R10", "outputs after reset", {mem_bad, geo_cfg, bank_end, row_mask}, 32'd0);
        chk("R4", "no request after reset", 32'(mem_req), 32'd0);
    endtask

    task automatic t_full_sequence();
        int mism = 0;
        int first = -1;
        set_model(32'hFFFF_FFFF, 0, 0, 0, 0);
        launch();
        expect_good("R8", 4'hB, 8'h40, 8'h3F);
        for (int k = 0; k < 9; k++) begin
            if (log_we[2*k] !== 1'b1 || log_addr[2*k] !== exp_a[k] || log_wd[2*k] !== exp_p[k]) begin mism++; if (first < 0) first = 2*k; end
            if (log_we[2*k+1] !== 1'b0 || log_addr[2*k+1] !== exp_a[k]) begin mism++; if (first < 0) first = 2*k+1; end
        end
        chk("R2", "write order and patterns (first bad op)", 32'(first), 32'hFFFF_FFFF);
        chk("R3", "readback pairing mismatches", 32'(mism), 32'd0);
        chk("R2", "verdict read 1 at row-12", log_addr[18], 32'h03000000);
        chk("R2", "verdict read 2 at row-14", log_addr[19], 32'h0F000000);
        chk("R2", "verdict read 3 at col-11", log_addr[20], 32'h0E001E00);
    endtask

    task automatic t_slow_memory();
        set_model(32'hFFFF_FFFF, 0, 3, 0, 0);
        launch();
        expect_good("R4", 4'hB, 8'h40, 8'h3F);
        chk("R4", "request held until ack", 32'(viol), 32'd0);
    endtask

    task automatic t_col9_row12();
        set_model(~32'h0C00_1800, 0, 1, 0, 0);
        launch();
        expect_good("R7", 4'h9, 8'h04, 8'h0F);
    endtask

    task automatic t_two_banks();
        set_model(32'hFFFF_FFFF, 1, 0, 0, 0);
        launch();
        expect_good("R5", 4'h3, 8'h40, 8'h3F);
    endtask

    task automatic t_row11_pat_col8();
        set_model(~32'h0200_1C00, 0, 2, 0, 0);
        launch();
        expect_good("R9", 4'h8, 8'h08, 8'h3F);
    endtask

    task automatic t_row11_col10();
        set_model(~32'h0E00_1000, 0, 0, 0, 0);
        launch();
        expect_good("R6", 4'hA, 8'h04, 8'h07);
    endtask

    task automatic t_fail_readback();
        set_model(32'hFFFF_FFFF, 0, 0, 2, 32'h1);
        launch();
        expect_bad("R3", 4);
    endtask

    task automatic t_fail_last_readback();
        set_model(32'hFFFF_FFFF, 0, 1, 9, 32'h0000_0100);
        launch();
        expect_bad("R3", 18);
    endtask

    task automatic t_fail_bank();
        set_model(32'hFFFF_FFFF, 0, 0, 10, 32'h0000_0100);
        launch();
        expect_bad("R5", 19);
    endtask

    task automatic t_fail_row_bytes();
        set_model(32'hFFFF_FFFF, 0, 0, 11, 32'h0000_0100);
        launch();
        expect_bad("R6", 20);
    endtask

    task automatic t_fail_row_low();
        set_model(32'hFFFF_FFFF, 0, 0, 11, 32'h3939_3939);
        launch();
        expect_bad("R6", 20);
    endtask

    task automatic t_fail_col_high();
        set_model(32'hFFFF_FFFF, 0, 0, 12, 32'h0707_0707);
        launch();
        expect_bad("R7", 21);
    endtask

    task automatic t_back_to_back();
        bit ok;
        set_model(32'hFFFF_FFFF, 0, 0, 0, 0);
        launch();
        wait_done("R12", ok);
        chk("R12", "first result", 32'(geo_cfg), 32'hB);
        set_model(~32'h0E00_1000, 0, 1, 0, 0);
        start = 1'b1; mdl_clr = 1'b1;
        @(negedge clk);
        start = 1'b0; mdl_clr = 1'b0;
        chk("R12", "restart request in next cycle", 32'(mem_req), 32'd1);
        repeat (5) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R12", "old result held mid-run", {geo_cfg, bank_end}, {20'd0, 4'hB, 8'h40});
        wait_done("R12", ok);
        chk("R12", "second result", 32'(geo_cfg), 32'hA);
        chk("R9", "second end value", 32'(bank_end), 32'h04);
        chk("R1", "start while busy ignored", 32'(nops), 32'd21);
        @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_full_sequence();
        t_slow_memory();
        t_col9_row12();
        t_two_banks();
        t_row11_pat_col8();
        t_row11_col10();
        t_fail_readback();
        t_fail_last_readback();
        t_fail_bank();
        t_fail_row_bytes();
        t_fail_row_low();
        t_fail_col_high();
        t_back_to_back();
        summary();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
    end

endmodule